// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Alarm

This block keeps wall-clock time as four packed-BCD fields: tenths of a second, seconds, minutes and a 12-hour hour field that carries a PM flag in its top bit. A slow strobe at mains rate (`tick_in`) drives a prescaler. When `rate_sel` is high the prescaler divides by five, and when it is low it divides by six, so the clock advances one tenth per prescaler period for either 50 Hz or 60 Hz mains. Each field carries into the next when it wraps. When the hour passes 11 it returns to 00 and the PM flag flips.

A second register set holds an alarm time in the same format. A byte write lands in either the time set or the alarm set, chosen by `wr_to_alarm`. Masks drop the bits that each field does not use. After every tenth advance the new time is compared with the alarm. On an exact match of all four fields, `alarm_pulse` is high for one cycle.

Reads are combinational from `rd_addr`. A read strobe on the hours field captures the whole time into a snapshot, and later reads see that snapshot while the live count keeps running. A read strobe on the tenths field releases the snapshot.

Top module: `tod_clock`

## Requirements
- R1: After synchronous reset, all four time fields read 0x00, the alarm fields are zero, the prescaler count is zero and `alarm_pulse` is low.
- R2: With the prescaler at zero, a tick advances the time and reloads the prescaler. The reload is 5 when `rate_sel`=0, giving one advance per 6 ticks, and 4 when `rate_sel`=1, giving one advance per 5 ticks. Any other tick only decrements the prescaler. Without a tick or a write the time holds.
- R3: Tenths (field address 0) count 0 to 9. Going past 9 they return to 0 and carry into the seconds.
- R4: Seconds (address 1) and minutes (address 2) count as packed BCD from 0x00 to 0x59. Going past 0x59 they return to 0x00 and carry into the next field.
- R5: Hours (address 3) count in BCD in bits 4:0, with bit 7 as the PM flag: 0x09 goes to 0x10. Going past 0x11 the hour returns to 0x00 and bit 7 toggles, so 0x11 goes to 0x80 and 0x91 goes to 0x00.
- R6: Written bytes are masked with 0x0F for tenths, 0x7F for seconds and minutes, and 0x9F for hours.
- R7: A write with `wr_to_alarm`=1 updates only the alarm field and leaves the time unchanged. A write with `wr_to_alarm`=0 updates only the time field.
- R8: `alarm_pulse` is high for exactly the one cycle after an advancing tick, and only if the advanced time equals the alarm in all four fields.
- R9: A read strobe (`rd_en`=1) on address 3 snapshots the time, and later reads return the snapshot while counting continues. A read strobe on address 0 returns the snapshot tenths and then releases the snapshot, so reads return live values again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | One-cycle strobe at mains rate |
| rate_sel | input | 1 | 1: divide ticks by 5, 0: divide by 6 |
| wr_en | input | 1 | Write strobe |
| wr_to_alarm | input | 1 | 1: write targets the alarm set, 0: time set |
| wr_addr | input | 2 | Write field: 0 tenths, 1 seconds, 2 minutes, 3 hours |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe, drives the snapshot control |
| rd_addr | input | 2 | Read field, same encoding as wr_addr |
| rd_data | output | 8 | Selected field, live or snapshot |
| alarm_pulse | output | 1 | One-cycle alarm match pulse |

## Verification
A wrong carry or wrap in the cascade shows at the ports on the next advancing tick, as a field value that is not BCD or a neighbour that failed to move. The bench therefore presets boundary times and reads all four fields after a single advance. A prescaler fault shifts the tick on which the tenths move, and this appears within one prescaler period. A stuck snapshot shows on the first read after a release. A wrong compare shows as a missing or early `alarm_pulse` in the cycle after the matching tick.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] MASK_TENTHS = 8'h0F;
    localparam logic [7:0] MASK_SEXA   = 8'h7F;
    localparam logic [7:0] MASK_HOUR   = 8'h9F;

    typedef enum logic [1:0] {
        FLD_TENTHS = 2'd0,
        FLD_SEC    = 2'd1,
        FLD_MIN    = 2'd2,
        FLD_HOUR   = 2'd3
    } tod_field_e;

    typedef struct packed {
        logic [7:0] hr;
        logic [6:0] mn;
        logic [6:0] sc;
        logic [3:0] tn;
    } tod_time_t;

    // Sexagesimal BCD step: returns {carry, next value}
    function automatic logic [7:0] bcd60_step(input logic [6:0] v);
        logic [4:0] lo;
        logic [3:0] hi;
        lo = {1'b0, v[3:0]} + 5'd1;
        hi = {1'b0, v[6:4]};
        if (lo > 5'd9) begin
            lo = 5'd0;
            hi = hi + 4'd1;
        end
        if (hi > 4'd5) return {1'b1, 7'd0};
        return {1'b0, hi[2:0], lo[3:0]};
    endfunction

    // Hour step with PM flag in bit 7
    function automatic logic [7:0] hour_step(input logic [7:0] v);
        logic [4:0] lo;
        logic [1:0] hi;
        logic [5:0] val;
        lo = {1'b0, v[3:0]} + 5'd1;
        hi = {1'b0, v[4]};
        if (lo > 5'd9) begin
            lo = 5'd0;
            hi = hi + 2'd1;
        end
        val = {hi, lo[3:0]};
        if (val[4:0] > 5'h11) return {~v[7], 7'd0};
        return {v[7], 1'b0, val};
    endfunction

    function automatic tod_time_t tod_advance(input tod_time_t t);
        tod_time_t  r;
        logic [7:0] s_step;
        logic [7:0] m_step;
        r = t;
        if (t.tn >= 4'd9) begin
            r.tn   = 4'd0;
            s_step = bcd60_step(t.sc);
            r.sc   = s_step[6:0];
            if (s_step[7]) begin
                m_step = bcd60_step(t.mn);
                r.mn   = m_step[6:0];
                if (m_step[7]) r.hr = hour_step(t.hr);
            end
        end else begin
            r.tn = t.tn + 4'd1;
        end
        return r;
    endfunction

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
    parameter int RELOAD_SLOW = 5,
    parameter int RELOAD_FAST = 4,
    localparam int DIV_W = $clog2(RELOAD_SLOW + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_in,
    input  logic rate_sel,
    output logic advance
);
    logic [DIV_W-1:0] div_q;

    assign advance = tick_in && (div_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (tick_in) begin
            if (div_q == '0)
                div_q <= rate_sel ? DIV_W'(RELOAD_FAST) : DIV_W'(RELOAD_SLOW);
            else
                div_q <= div_q - 1'b1;
        end
    end
endmodule

// File: rtl/tod_time_regs.sv
module tod_time_regs
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       advance,
    input  logic       wr_en,
    input  logic [1:0] wr_field,
    input  logic [7:0] wr_data,
    output tod_time_t  live
);
    tod_time_t t_q;
    tod_time_t t_d;

    always_comb begin
        t_d = advance ? tod_advance(t_q) : t_q;
        if (wr_en) begin
            case (tod_field_e'(wr_field))
                FLD_TENTHS: t_d.tn = wr_data[3:0];
                FLD_SEC:    t_d.sc = wr_data[6:0];
                FLD_MIN:    t_d.mn = wr_data[6:0];
                FLD_HOUR:   t_d.hr = wr_data & MASK_HOUR;
                default:    t_d = t_d;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign live = t_q;
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       advance,
    input  tod_time_t  live,
    input  logic       wr_en,
    input  logic [1:0] wr_field,
    input  logic [7:0] wr_data,
    output logic       alarm_pulse
);
    tod_time_t alm_q;
    tod_time_t stepped;
    logic      pulse_q;

    assign stepped = tod_advance(live);

    always_ff @(posedge clk) begin
        if (rst) begin
            alm_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= advance && (stepped == alm_q);
            if (wr_en) begin
                case (tod_field_e'(wr_field))
                    FLD_TENTHS: alm_q.tn <= wr_data[3:0];
                    FLD_SEC:    alm_q.sc <= wr_data[6:0];
                    FLD_MIN:    alm_q.mn <= wr_data[6:0];
                    FLD_HOUR:   alm_q.hr <= wr_data & MASK_HOUR;
                    default:    alm_q <= alm_q;
                endcase
            end
        end
    end

    assign alarm_pulse = pulse_q;
endmodule

// File: rtl/tod_read_view.sv
module tod_read_view
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_en,
    input  logic [1:0] rd_field,
    input  tod_time_t  live,
    output logic       frozen,
    output tod_time_t  snap,
    output logic [7:0] rd_data
);
    logic      frozen_q;
    tod_time_t snap_q;
    tod_time_t view;

    always_ff @(posedge clk) begin
        if (rst) begin
            frozen_q <= 1'b0;
            snap_q   <= '0;
        end else if (rd_en) begin
            if (tod_field_e'(rd_field) == FLD_HOUR && !frozen_q) begin
                frozen_q <= 1'b1;
                snap_q   <= live;
            end else if (tod_field_e'(rd_field) == FLD_TENTHS) begin
                frozen_q <= 1'b0;
            end
        end
    end

    assign view = frozen_q ? snap_q : live;

    always_comb begin
        case (tod_field_e'(rd_field))
            FLD_TENTHS: rd_data = {4'd0, view.tn};
            FLD_SEC:    rd_data = {1'b0, view.sc};
            FLD_MIN:    rd_data = {1'b0, view.mn};
            default:    rd_data = view.hr;
        endcase
    end

    assign frozen = frozen_q;
    assign snap   = snap_q;
endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int RELOAD_SLOW = 5,
    parameter int RELOAD_FAST = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_in,
    input  logic       rate_sel,
    input  logic       wr_en,
    input  logic       wr_to_alarm,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       alarm_pulse
);
    logic      advance;
    logic      frozen;
    tod_time_t live_time;
    tod_time_t snap_time;

    tod_prescaler #(
        .RELOAD_SLOW (RELOAD_SLOW),
        .RELOAD_FAST (RELOAD_FAST)
    ) i_presc (
        .clk      (clk),
        .rst      (rst),
        .tick_in  (tick_in),
        .rate_sel (rate_sel),
        .advance  (advance)
    );

    tod_time_regs i_time (
        .clk      (clk),
        .rst      (rst),
        .advance  (advance),
        .wr_en    (wr_en && !wr_to_alarm),
        .wr_field (wr_addr),
        .wr_data  (wr_data),
        .live     (live_time)
    );

    tod_alarm i_alarm (
        .clk         (clk),
        .rst         (rst),
        .advance     (advance),
        .live        (live_time),
        .wr_en       (wr_en && wr_to_alarm),
        .wr_field    (wr_addr),
        .wr_data     (wr_data),
        .alarm_pulse (alarm_pulse)
    );

    tod_read_view i_view (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_field (rd_addr),
        .live     (live_time),
        .frozen   (frozen),
        .snap     (snap_time),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/tod_clock_checker.sv
module tod_clock_checker
    import tod_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      tick_in,
    input logic      wr_en,
    input logic      wr_to_alarm,
    input logic      advance,
    input logic      frozen,
    input tod_time_t live,
    input tod_time_t snap,
    input logic      alarm_pulse
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (live == '0 && !alarm_pulse));  // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!tick_in && !wr_en) |=> $stable(live));  // R2

    AST_ADVANCE_SPACED: assert property (@(posedge clk) disable iff (rst)
        advance |=> !advance);  // R2

    AST_ALARM_WRITE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_to_alarm && !tick_in) |=> $stable(live));  // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        alarm_pulse |=> !alarm_pulse);  // R8

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        alarm_pulse |-> $past(advance));  // R8

    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (rst)
        frozen |=> $stable(snap));  // R9
endmodule

bind tod_clock tod_clock_checker i_tod_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_in     (tick_in),
    .wr_en       (wr_en),
    .wr_to_alarm (wr_to_alarm),
    .advance     (advance),
    .frozen      (frozen),
    .live        (live_time),
    .snap        (snap_time),
    .alarm_pulse (alarm_pulse)
);

// File: tb/test_tod_clock.sv
module test_tod_clock;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_in = 1'b0;
    logic       rate_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_to_alarm = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       alarm_pulse;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tod_clock i_tod_clock (
        .clk         (clk),
        .rst         (rst),
        .tick_in     (tick_in),
        .rate_sel    (rate_sel),
        .wr_en       (wr_en),
        .wr_to_alarm (wr_to_alarm),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .alarm_pulse (alarm_pulse)
    );

    // {preset hr,mn,sc,tn , expected hr,mn,sc,tn after one advance}
    localparam logic [63:0] VEC [8] = '{
        64'h00000000_00000001,  // R3
        64'h00000009_00000100,  // R3
        64'h00005909_00010000,  // R4
        64'h00595909_01000000,  // R4
        64'h09595909_10000000,  // R5
        64'h11595909_80000000,  // R5
        64'h91595909_00000000,  // R5
        64'h05341909_05342000   // R4
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_field(input logic to_alarm, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_to_alarm = to_alarm; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_to_alarm = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_in = 1'b1;
        @(negedge clk);
        tick_in = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        rd_en = 1'b0;
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic read_strobe(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = a;
        #1;
        d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] v;

        // R1: reset state
        do_reset();
        for (int f = 0; f < 4; f++) begin
            peek(2'(f), v);
            check("R1 reset field", v, 8'h00);
        end
        check("R1 reset pulse", {7'd0, alarm_pulse}, 8'h00);

        // Table walk: carries and wraps (R3 R4 R5)
        for (int i = 0; i < 8; i++) begin
            do_reset();
            write_field(1'b0, 2'd3, VEC[i][63:56]);
            write_field(1'b0, 2'd2, VEC[i][55:48]);
            write_field(1'b0, 2'd1, VEC[i][47:40]);
            write_field(1'b0, 2'd0, VEC[i][39:32]);
            tick();
            for (int f = 0; f < 4; f++) begin
                peek(2'(f), v);
                check("R3/R4/R5 advance", v, VEC[i][f*8 +: 8]);
            end
        end

        // R6: write masks
        do_reset();
        for (int f = 0; f < 4; f++) write_field(1'b0, 2'(f), 8'hFF);
        peek(2'd0, v); check("R6 tenths mask", v, 8'h0F);
        peek(2'd1, v); check("R6 seconds mask", v, 8'h7F);
        peek(2'd2, v); check("R6 minutes mask", v, 8'h7F);
        peek(2'd3, v); check("R6 hours mask", v, 8'h9F);

        // R7, R8, R2 (rate_sel=0): alarm at 00:00:00.3
        do_reset();
        rate_sel = 1'b0;
        write_field(1'b1, 2'd0, 8'hF3);
        peek(2'd0, v); check("R7 alarm write leaves time", v, 8'h00);
        tick();
        peek(2'd0, v); check("R2 first tick advances", v, 8'h01);
        check("R8 no match no pulse", {7'd0, alarm_pulse}, 8'h00);
        for (int k = 0; k < 5; k++) begin
            tick();
            peek(2'd0, v); check("R2 slow rate hold", v, 8'h01);
        end
        tick();
        peek(2'd0, v); check("R2 slow rate sixth tick", v, 8'h02);
        check("R8 no pulse at .2", {7'd0, alarm_pulse}, 8'h00);
        for (int k = 0; k < 5; k++) tick();
        check("R8 no pulse without advance", {7'd0, alarm_pulse}, 8'h00);
        tick();
        peek(2'd0, v); check("R3 tenths at 3", v, 8'h03);
        check("R8 pulse on match", {7'd0, alarm_pulse}, 8'h01);
        @(negedge clk);
        check("R8 pulse one cycle", {7'd0, alarm_pulse}, 8'h00);

        // R2 fast rate
        do_reset();
        rate_sel = 1'b1;
        tick();
        for (int k = 0; k < 4; k++) tick();
        peek(2'd0, v); check("R2 fast rate hold", v, 8'h01);
        tick();
        peek(2'd0, v); check("R2 fast rate fifth tick", v, 8'h02);
        rate_sel = 1'b0;

        // R9: read snapshot
        do_reset();
        write_field(1'b0, 2'd3, 8'h05);
        read_strobe(2'd3, v); check("R9 hours read live", v, 8'h05);
        tick();
        peek(2'd0, v); check("R9 frozen tenths", v, 8'h00);
        peek(2'd3, v); check("R9 frozen hours", v, 8'h05);
        read_strobe(2'd0, v); check("R9 release read sees snapshot", v, 8'h00);
        peek(2'd0, v); check("R9 live after release", v, 8'h01);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule